// File: doc/BRIEF.md
# Word-Serial Modular Adder/Subtractor

This block computes either (a + b) mod q or (a − b) mod q for multi-word operands that are already below the modulus q. It walks the operands one word per clock, least significant word first. A pulse on `start` begins a pass. The block then drives a word index to three external word buffers, which hold a, b and q, and takes back the addressed words in the same cycle.

Two chains run in each word step. One forms the primary result: a + b in add mode, or a − b in subtract mode. The other applies the modulus to that partial word: it subtracts q in add mode and adds q in subtract mode. Each chain has its own carry or borrow. Both candidate words go into internal buffers. After the top word, the final chain flags pick one of the two candidates, and a one-cycle `done` pulse follows. From then on, any word of the selected result can be read by index until the next pass starts.

Top module: `mod_addsub_serial`

## Requirements
- R1: After reset, `done` is 0, `op_idx` is 0 and `rd_word` reads 0 for every `rd_idx`.
- R2: When `start` is sampled high while the block is idle, `op_idx` takes the values 0, 1, …, N−1 on consecutive cycles, and `done` is high for exactly one cycle, N cycles after the sampling edge.
- R3: A `start` pulse that arrives during a pass is ignored. It neither restarts the pass nor causes a second `done`.
- R4: With `sub_mode` = 0 and a, b < q, the result equals (a + b) mod q.
- R5: In add mode the boundaries reduce correctly. When a + b = q the result is 0. When a + b = q − 1 the result is q − 1. When a + b overflows the N-word width, the sum minus q is chosen, because the final carry cancels the final borrow.
- R6: With `sub_mode` = 1 and a, b < q, the result equals (a − b) mod q.
- R7: In subtract mode, a = b gives 0, and a = 0 gives q − b.
- R8: After `done`, the result stays unchanged and can be read in any word order until the next accepted `start`.
- R9: `sub_mode` is captured on the `start` edge. Changing it during a pass has no effect on that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a pass when the block is idle |
| sub_mode | input | 1 | 0 = modular add, 1 = modular subtract; sampled with `start` |
| op_idx | output | IDX_W | Word index driven to the operand buffers |
| a_word | input | WORD_W | Word of a at `op_idx` |
| b_word | input | WORD_W | Word of b at `op_idx` |
| q_word | input | WORD_W | Word of the modulus at `op_idx` |
| rd_idx | input | IDX_W | Word index for reading the result |
| rd_word | output | WORD_W | Word of the selected result at `rd_idx` |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The hardest case to reach is the add-mode overflow. Here a + b carries out of the top word, and that final carry must cancel the final borrow of the q chain. Random moduli almost never produce it. The bench therefore uses a modulus just below 2^256 with a = b = q − 1. Exact-boundary sums such as a + b = q are built from a random a with b = q − a. The bench also drives a stray `start` and a flip of `sub_mode` in the middle of a pass, then checks the latency and the value of that pass's result.

// File: rtl/modarith_pkg.sv
package modarith_pkg;

    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } op_mode_e;

endpackage

// File: rtl/mas_word_step.sv
module mas_word_step
    import modarith_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  op_mode_e          mode,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic [WORD_W-1:0] q_in,
    input  logic              pri_cy_in,
    input  logic              alt_cy_in,
    output logic [WORD_W-1:0] pri_out,
    output logic [WORD_W-1:0] alt_out,
    output logic              pri_cy_out,
    output logic              alt_cy_out
);

    logic [WORD_W:0] pri_full;
    logic [WORD_W:0] alt_full;

    // Primary chain: a+b (carry) or a-b (borrow); both show up in bit WORD_W.
    always_comb begin
        if (mode == MODE_ADD) begin
            pri_full = {1'b0, a_in} + {1'b0, b_in} + {{WORD_W{1'b0}}, pri_cy_in};
        end else begin
            pri_full = {1'b0, a_in} - {1'b0, b_in} - {{WORD_W{1'b0}}, pri_cy_in};
        end
    end

    // Correction chain on the primary word: minus q (borrow) or plus q (carry).
    always_comb begin
        if (mode == MODE_ADD) begin
            alt_full = {1'b0, pri_full[WORD_W-1:0]} - {1'b0, q_in} - {{WORD_W{1'b0}}, alt_cy_in};
        end else begin
            alt_full = {1'b0, pri_full[WORD_W-1:0]} + {1'b0, q_in} + {{WORD_W{1'b0}}, alt_cy_in};
        end
    end

    assign pri_out    = pri_full[WORD_W-1:0];
    assign alt_out    = alt_full[WORD_W-1:0];
    assign pri_cy_out = pri_full[WORD_W];
    assign alt_cy_out = alt_full[WORD_W];

endmodule

// File: rtl/mas_final_select.sv
module mas_final_select
    import modarith_pkg::*;
(
    input  op_mode_e mode,
    input  logic     pri_flag,
    input  logic     alt_flag,
    output logic     take_alt
);

    // Add: pri_flag = carry of a+b, alt_flag = borrow of minus q.
    //      Keep the plain sum only when it is below q (borrow without carry).
    // Sub: pri_flag = borrow of a-b; a negative difference takes the +q word.
    always_comb begin
        if (mode == MODE_ADD) begin
            take_alt = !(alt_flag && !pri_flag);
        end else begin
            take_alt = pri_flag;
        end
    end

endmodule

// File: rtl/mas_cand_store.sv
module mas_cand_store #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] pri_in,
    input  logic [WORD_W-1:0] alt_in,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              use_alt,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] pri_mem [NUM_WORDS];
    logic [WORD_W-1:0] alt_mem [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pri_mem[g] <= '0;
                alt_mem[g] <= '0;
            end else if (wr_en && (int'(wr_idx) == g)) begin
                pri_mem[g] <= pri_in;
                alt_mem[g] <= alt_in;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (int'(rd_idx) < NUM_WORDS) begin
            rd_word = use_alt ? alt_mem[rd_idx] : pri_mem[rd_idx];
        end
    end

endmodule

// File: rtl/mod_addsub_serial.sv
module mod_addsub_serial
    import modarith_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sub_mode,
    output logic [IDX_W-1:0]  op_idx,
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic [WORD_W-1:0] q_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic             pri_cy;
        logic             alt_cy;
        op_mode_e         mode;
        logic             use_alt;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WORD_W-1:0] step_pri;
    logic [WORD_W-1:0] step_alt;
    logic              step_pri_cy;
    logic              step_alt_cy;
    logic              final_alt;
    logic              busy_w;

    mas_word_step #(.WORD_W(WORD_W)) u_step (
        .mode       (ctl_q.mode),
        .a_in       (a_word),
        .b_in       (b_word),
        .q_in       (q_word),
        .pri_cy_in  (ctl_q.pri_cy),
        .alt_cy_in  (ctl_q.alt_cy),
        .pri_out    (step_pri),
        .alt_out    (step_alt),
        .pri_cy_out (step_pri_cy),
        .alt_cy_out (step_alt_cy)
    );

    mas_final_select u_sel (
        .mode     (ctl_q.mode),
        .pri_flag (step_pri_cy),
        .alt_flag (step_alt_cy),
        .take_alt (final_alt)
    );

    mas_cand_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_q.busy),
        .wr_idx  (ctl_q.idx),
        .pri_in  (step_pri),
        .alt_in  (step_alt),
        .rd_idx  (rd_idx),
        .use_alt (ctl_q.use_alt),
        .rd_word (rd_word)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (!ctl_q.busy) begin
            if (start) begin
                ctl_d.busy   = 1'b1;
                ctl_d.idx    = '0;
                ctl_d.pri_cy = 1'b0;
                ctl_d.alt_cy = 1'b0;
                ctl_d.mode   = sub_mode ? MODE_SUB : MODE_ADD;
            end
        end else begin
            ctl_d.pri_cy = step_pri_cy;
            ctl_d.alt_cy = step_alt_cy;
            if (ctl_q.idx == LAST_IDX) begin
                ctl_d.busy    = 1'b0;
                ctl_d.idx     = '0;
                ctl_d.done    = 1'b1;
                ctl_d.use_alt = final_alt;
            end else begin
                ctl_d.idx = ctl_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{busy: 1'b0, idx: '0, pri_cy: 1'b0, alt_cy: 1'b0,
                       mode: MODE_ADD, use_alt: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign op_idx = ctl_q.idx;
    assign done   = ctl_q.done;
    assign busy_w = ctl_q.busy;

endmodule

// File: rtl/mod_addsub_serial_chk.sv
module mod_addsub_serial_chk #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic [IDX_W-1:0]  op_idx,
    input logic              done,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [WORD_W-1:0] rd_word
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_idx == LAST_IDX) |=> (done && !busy)); // R2

    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_idx != LAST_IDX) |=> (busy && op_idx == $past(op_idx) + IDX_W'(1))); // R2

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && op_idx != LAST_IDX) |=> (busy && op_idx != '0)); // R3

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ((rd_idx != $past(rd_idx)) || $stable(rd_word))); // R8

endmodule

bind mod_addsub_serial mod_addsub_serial_chk #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy_w),
    .op_idx  (op_idx),
    .done    (done),
    .rd_idx  (rd_idx),
    .rd_word (rd_word)
);

// File: tb/sim_mod_addsub_serial.sv
`timescale 1ns/100ps
module sim_mod_addsub_serial;

    localparam int W     = 32;
    localparam int N     = 8;
    localparam int IW    = 3;
    localparam int WIDE  = W * N;

    typedef logic [WIDE-1:0] wide_t;
    typedef struct {
        wide_t       exp;
        int unsigned start_cyc;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          sub_mode = 1'b0;
    logic [IW-1:0] op_idx;
    logic [W-1:0]  a_word, b_word, q_word;
    logic [IW-1:0] rd_idx, rd_idx_mon = '0, rd_idx_drv = '0;
    logic          reread_on = 1'b0;
    logic [W-1:0]  rd_word;
    logic          done;

    logic [W-1:0] a_mem [N];
    logic [W-1:0] b_mem [N];
    logic [W-1:0] q_mem [N];

    int unsigned cyc = 0;
    int n_chk = 0, n_fail = 0, mon_cnt = 0;
    item_t sb[$];
    wide_t last_exp;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign a_word = a_mem[op_idx];
    assign b_word = b_mem[op_idx];
    assign q_word = q_mem[op_idx];
    assign rd_idx = reread_on ? rd_idx_drv : rd_idx_mon;

    mod_addsub_serial #(.WORD_W(W), .NUM_WORDS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sub_mode(sub_mode),
        .op_idx(op_idx), .a_word(a_word), .b_word(b_word), .q_word(q_word),
        .rd_idx(rd_idx), .rd_word(rd_word), .done(done)
    );

    function automatic wide_t rand_wide();
        wide_t r;
        for (int i = 0; i < N; i++) r[i*W +: W] = $urandom;
        return r;
    endfunction

    function automatic wide_t ref_calc(wide_t a, wide_t b, wide_t q, bit sub);
        logic [WIDE+1:0] t;
        if (sub) t = {2'b0, a} + {2'b0, q} - {2'b0, b};
        else     t = {2'b0, a} + {2'b0, b};
        t = t % {2'b0, q};
        return t[WIDE-1:0];
    endfunction

    task automatic check(bit ok, string req, wide_t act, wide_t exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: loads operand buffers, pulses start, pushes the expected item.
    task automatic run_op(wide_t a, wide_t b, wide_t q, bit sub, string tag,
                          bit flip_mode = 1'b0, bit extra_start = 1'b0);
        item_t it;
        int target;
        for (int i = 0; i < N; i++) begin
            a_mem[i] = a[i*W +: W];
            b_mem[i] = b[i*W +: W];
            q_mem[i] = q[i*W +: W];
        end
        target = mon_cnt + 1;
        @(negedge clk);
        sub_mode = sub;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        it.exp = ref_calc(a, b, q, sub);
        it.start_cyc = cyc;
        it.tag = tag;
        sb.push_back(it);
        if (flip_mode) sub_mode = ~sub;
        if (extra_start) begin
            @(negedge clk); @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (mon_cnt < target) @(negedge clk);
        sub_mode = 1'b0;
    endtask

    // Monitor: on done, pop the expected item and compare latency and value.
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                item_t it;
                wide_t got;
                if (sb.size() == 0) begin
                    check(1'b0, "R3 unexpected done", '1, '0);
                end else begin
                    it = sb.pop_front();
                    check((cyc - it.start_cyc) == N, "R2 latency",
                          wide_t'(cyc - it.start_cyc), wide_t'(N));
                    for (int i = 0; i < N; i++) begin
                        rd_idx_mon = IW'(i);
                        #0.2;
                        got[i*W +: W] = rd_word;
                    end
                    check(got == it.exp, it.tag, got, it.exp);
                    last_exp = it.exp;
                end
                mon_cnt++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wide_t q, a, b, qbig, got;
        bit rd_zero;
        for (int i = 0; i < N; i++) begin
            a_mem[i] = '0; b_mem[i] = '0; q_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1 done after reset", wide_t'(done), '0);
        check(op_idx == '0, "R1 op_idx after reset", wide_t'(op_idx), '0);
        rd_zero = 1'b1;
        for (int i = 0; i < N; i++) begin
            rd_idx_mon = IW'(i);
            #0.2;
            if (rd_word != '0) rd_zero = 1'b0;
        end
        check(rd_zero, "R1 result buffer cleared", wide_t'(!rd_zero), '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 / R6: random operands below random moduli
        for (int k = 0; k < 6; k++) begin
            q = rand_wide(); q[WIDE-1] = 1'b1;
            a = rand_wide() % q; b = rand_wide() % q;
            run_op(a, b, q, 1'b0, "R4 add random");
            a = rand_wide() % q; b = rand_wide() % q;
            run_op(a, b, q, 1'b1, "R6 sub random");
        end

        // R5: add boundaries
        q = rand_wide(); q[WIDE-1] = 1'b1;
        a = rand_wide() % q;
        run_op(a, q - a, q, 1'b0, "R5 a+b equals q");
        run_op(wide_t'(1), q - 1, q, 1'b0, "R5 b=q-1 plus one");
        run_op('0, q - 1, q, 1'b0, "R5 a=0 b=q-1");
        run_op(wide_t'(5), q - 6, q, 1'b0, "R5 a+b equals q-1");
        qbig = '1 - wide_t'(188);
        run_op(qbig - 1, qbig - 1, qbig, 1'b0, "R5 overflow carry cancels borrow");

        // R7: subtract boundaries
        a = rand_wide() % q;
        run_op(a, a, q, 1'b1, "R7 a equals b");
        b = rand_wide() % q;
        run_op('0, b, q, 1'b1, "R7 a=0");
        run_op('0, q - 1, q, 1'b1, "R7 a=0 b=q-1");

        // R9: mode flipped mid-pass
        a = rand_wide() % q; b = rand_wide() % q;
        run_op(a, b, q, 1'b0, "R9 add held against mode flip", 1'b1, 1'b0);
        run_op(a, b, q, 1'b1, "R9 sub held against mode flip", 1'b1, 1'b0);

        // R3: stray start during a pass
        run_op(a, b, q, 1'b0, "R3 stray start ignored", 1'b0, 1'b1);
        repeat (3 * N) @(negedge clk);
        check(sb.size() == 0, "R3 no extra pass queued", wide_t'(sb.size()), '0);

        // R8: re-read in reverse order after idle cycles
        repeat (5) @(negedge clk);
        reread_on = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            rd_idx_drv = IW'(i);
            #0.2;
            got[i*W +: W] = rd_word;
        end
        reread_on = 1'b0;
        check(got == last_exp, "R8 result held reverse read", got, last_exp);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule